// File: doc/BRIEF.md
# Dual-Mode Interval Timer

A single timer channel programmed through a small 32-bit register bus with single-cycle writes and combinational reads. Software places a 64-bit start value in two 32-bit words, then switches the channel on. From that moment a 64-bit down-counter steps once for each cycle in which the `tick` enable input is high. When the count reaches zero on a tick, the channel signals an expiry.

Two behaviours are selectable. In periodic mode the counter refills itself from the captured start value and keeps running, so a start value of N gives one expiry every N+1 ticks. In single-shot mode the counter expires once, parks at zero and does nothing more until software switches it off and on again. Each expiry sets a sticky pending flag that software clears by writing a one. A mask bit gates that flag onto the level-high `irq` output.

The intended programming order is: switch off, write the two start-value words, then switch on with the mode and mask bits chosen. Switching on is what restarts the count.

Top module: `ivt_top`

## Requirements
- R1: After synchronous reset every register reads zero (start value, current count, control, pending flag), and `irq` is low.
- R2: Register offsets are fixed, because software decodes them: start value low word 0x00 and high word 0x04 (read/write), current count low word 0x08 and high word 0x0C (read only), control 0x10 (read/write, bits above 2 read as zero), pending flag 0x18 (bit 0). Any other offset reads zero.
- R3: Control bit 0 is the run enable. A write that takes it from 0 to 1 loads the counter with {high word, low word} on the next edge. While enabled, each `tick` lowers the count by one. While disabled, ticks leave the count unchanged.
- R4: With control bit 1 equal to 0 (periodic), the tick that finds the count at zero is an expiry and reloads the captured start value, so start value N expires every N+1 ticks.
- R5: With control bit 1 equal to 1 (single-shot), the first expiry leaves the count at zero. Later ticks neither change the count nor set the pending flag again until the next 0-to-1 enable.
- R6: Writing the start-value words while enabled changes neither the running count nor the value used for periodic reloads. The new value takes effect only at the next 0-to-1 enable.
- R7: Every expiry sets pending bit 0 at 0x18 whatever the mask. Writing 1 to bit 0 clears it, and writing 0 has no effect. An expiry in the same cycle as a clear leaves it set.
- R8: `irq` is high exactly while the pending flag and control bit 2 (unmask) are both set. It stays high until the flag is cleared or the mask bit is dropped.
- R9: The counter is a true 64-bit counter: decrementing a count whose low word is zero borrows from the high word.
- R10: A control write that keeps bit 0 at 1 updates the mode and mask bits but does not restart the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Count enable; one count step per high cycle |
| bus_wr | input | 1 | Write strobe, single cycle |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| irq | output | 1 | Level-high interrupt request |

## Verification
A wrong internal count shows up at the count read-back words in the same cycle. If the captured reload value or the single-shot done state is wrong, the error surfaces at the pending flag and `irq` no later than one period after the fault, when an expiry comes early, late, twice or not at all. The bench runs a behavioural model alongside the design and compares the count words and `irq` after every clock. Because of that, a divergence is reported in the cycle it first becomes visible, not at the end of a test phase.

// File: rtl/ivt_pkg.sv
package ivt_pkg;

    // Register byte offsets (software decodes these)
    localparam int OFS_LOAD_LO = 'h00;
    localparam int OFS_LOAD_HI = 'h04;
    localparam int OFS_CNT_LO  = 'h08;
    localparam int OFS_CNT_HI  = 'h0C;
    localparam int OFS_CTRL    = 'h10;
    localparam int OFS_PEND    = 'h18;
    localparam int WORD_BYTES  = 4;
    localparam int CTRL_BITS   = 3;

    typedef enum logic {
        MODE_PERIODIC = 1'b0,
        MODE_ONESHOT  = 1'b1
    } run_mode_e;

    // bit 2 unmask, bit 1 mode, bit 0 enable
    typedef struct packed {
        logic      unmask;
        run_mode_e mode;
        logic      en;
    } ctrl_t;

    function automatic ctrl_t decode_ctrl(input logic [CTRL_BITS-1:0] raw);
        ctrl_t c;
        c.unmask = raw[2];
        c.mode   = run_mode_e'(raw[1]);
        c.en     = raw[0];
        return c;
    endfunction

endpackage

// File: rtl/ivt_regs.sv
module ivt_regs
    import ivt_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 32,
    localparam int CNT_W = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [CNT_W-1:0]  count,
    input  logic              pending,
    output logic [DATA_W-1:0] bus_rdata,
    output ctrl_t             ctrl,
    output logic [CNT_W-1:0]  load_val,
    output logic              start,
    output logic              clr
);
    logic hit_ctrl, hit_pend;
    logic [DATA_W-1:0] load_w [2];
    logic [DATA_W-1:0] rd_load, rd_cnt;

    assign hit_ctrl = (bus_addr == ADDR_W'(OFS_CTRL));
    assign hit_pend = (bus_addr == ADDR_W'(OFS_PEND));

    // Start value words, one register per half
    for (genvar g = 0; g < 2; g++) begin : g_load
        always_ff @(posedge clk) begin
            if (rst) begin
                load_w[g] <= '0;
            end else if (bus_wr && bus_addr == ADDR_W'(OFS_LOAD_LO + g * WORD_BYTES)) begin
                load_w[g] <= bus_wdata;
            end
        end
        assign load_val[g*DATA_W +: DATA_W] = load_w[g];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
        end else if (bus_wr && hit_ctrl) begin
            ctrl <= decode_ctrl(bus_wdata[CTRL_BITS-1:0]);
        end
    end

    // Restart only on an off-to-on transition
    assign start = bus_wr && hit_ctrl && bus_wdata[0] && !ctrl.en;
    assign clr   = bus_wr && hit_pend && bus_wdata[0];

    always_comb begin
        rd_load = load_w[bus_addr[2]];
        rd_cnt  = count[(bus_addr[2] ? DATA_W : 0) +: DATA_W];
        case (bus_addr)
            ADDR_W'(OFS_LOAD_LO), ADDR_W'(OFS_LOAD_HI): bus_rdata = rd_load;
            ADDR_W'(OFS_CNT_LO),  ADDR_W'(OFS_CNT_HI):  bus_rdata = rd_cnt;
            ADDR_W'(OFS_CTRL):  bus_rdata = DATA_W'(ctrl);
            ADDR_W'(OFS_PEND):  bus_rdata = DATA_W'(pending);
            default:            bus_rdata = '0;
        endcase
    end

    AST_CTRL_WRITE: assert property (@(posedge clk) disable iff (rst)
        bus_wr && hit_ctrl |=> ctrl == decode_ctrl($past(bus_wdata[CTRL_BITS-1:0]))); // R2

endmodule

// File: rtl/ivt_counter.sv
module ivt_counter
    import ivt_pkg::*;
#(
    parameter int CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             en,
    input  run_mode_e        mode,
    input  logic             start,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] count,
    output logic             expire
);
    logic [CNT_W-1:0] act_q;
    logic             done_q;
    logic             step, at_zero;

    assign at_zero = (count == '0);
    assign step    = en && !done_q && tick && !start;
    assign expire  = step && at_zero;

    always_ff @(posedge clk) begin
        if (rst) begin
            count  <= '0;
            act_q  <= '0;
            done_q <= 1'b0;
        end else if (start) begin
            count  <= load_val;
            act_q  <= load_val;
            done_q <= 1'b0;
        end else if (step) begin
            if (at_zero) begin
                if (mode == MODE_PERIODIC) count <= act_q;
                else                       done_q <= 1'b1;
            end else begin
                count <= count - 1'b1;
            end
        end
    end

    AST_START_LOADS: assert property (@(posedge clk) disable iff (rst)
        start |=> count == $past(load_val)); // R3

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !en && !start |=> $stable(count)); // R3

    AST_PERIODIC_RELOAD: assert property (@(posedge clk) disable iff (rst)
        expire && mode == MODE_PERIODIC |=> count == $past(act_q)); // R4

    AST_ONESHOT_PARKED: assert property (@(posedge clk) disable iff (rst)
        done_q && !start |=> count == '0 && !expire); // R5

endmodule

// File: rtl/ivt_irq.sv
module ivt_irq (
    input  logic clk,
    input  logic rst,
    input  logic expire,
    input  logic clr,
    input  logic unmask,
    output logic pending,
    output logic irq
);
    always_ff @(posedge clk) begin
        if (rst)         pending <= 1'b0;
        else if (expire) pending <= 1'b1;
        else if (clr)    pending <= 1'b0;
    end

    assign irq = pending && unmask;

    AST_EXPIRE_SETS: assert property (@(posedge clk) disable iff (rst)
        expire |=> pending); // R7

    AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (rst)
        clr && !expire |=> !pending); // R7

    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (rst)
        pending && !clr |=> pending); // R8

endmodule

// File: rtl/ivt_top.sv
module ivt_top
    import ivt_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);
    localparam int CNT_W = 2 * DATA_W;

    ctrl_t            ctrl;
    logic [CNT_W-1:0] load_val, count;
    logic             start, clr, expire, pending;

    ivt_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .count(count), .pending(pending),
        .bus_rdata(bus_rdata), .ctrl(ctrl), .load_val(load_val),
        .start(start), .clr(clr)
    );

    ivt_counter #(.CNT_W(CNT_W)) u_counter (
        .clk(clk), .rst(rst), .tick(tick), .en(ctrl.en), .mode(ctrl.mode),
        .start(start), .load_val(load_val), .count(count), .expire(expire)
    );

    ivt_irq u_irq (
        .clk(clk), .rst(rst), .expire(expire), .clr(clr),
        .unmask(ctrl.unmask), .pending(pending), .irq(irq)
    );

    AST_IRQ_NEEDS_UNMASK: assert property (@(posedge clk) disable iff (rst)
        irq |-> ctrl.unmask); // R8

endmodule

// File: tb/ivt_top_tb.sv
module ivt_top_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick = 1'b0;
    logic        bwr = 1'b0;
    logic [4:0]  baddr = '0;
    logic [31:0] bwd = '0;
    logic [31:0] rdata;
    logic        irq;

    int checks = 0;
    int fails = 0;
    bit finished = 0;

    // behavioural reference state
    longint unsigned m_load, m_act, m_cnt;
    bit m_en, m_mode, m_unmask, m_done, m_pend;

    always #5 clk = ~clk;

    ivt_top u_dut (
        .clk(clk), .rst(rst), .tick(tick), .bus_wr(bwr), .bus_addr(baddr),
        .bus_wdata(bwd), .bus_rdata(rdata), .irq(irq)
    );

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_load = 0; m_act = 0; m_cnt = 0;
        m_en = 0; m_mode = 0; m_unmask = 0; m_done = 0; m_pend = 0;
    endtask

    // apply the rules of R3..R10 to one clock edge
    task automatic model_step(bit wr, logic [4:0] a, logic [31:0] d, bit tk);
        bit st, ex, cl;
        st = wr && a == 5'h10 && d[0] && !m_en;
        cl = wr && a == 5'h18 && d[0];
        ex = 0;
        if (st) begin
            m_cnt = m_load; m_act = m_load; m_done = 0;
        end else if (m_en && !m_done && tk) begin
            if (m_cnt == 0) begin
                ex = 1;
                if (!m_mode) m_cnt = m_act; else m_done = 1;
            end else m_cnt = m_cnt - 1;
        end
        if (ex) m_pend = 1; else if (cl) m_pend = 0;
        if (wr && a == 5'h10) begin
            m_en = d[0]; m_mode = d[1]; m_unmask = d[2];
        end
        if (wr && a == 5'h00) m_load[31:0]  = d;
        if (wr && a == 5'h04) m_load[63:32] = d;
    endtask

    // one clock with the given stimulus, then compare count words and irq
    task automatic cyc(bit wr, logic [4:0] a, logic [31:0] d, bit tk);
        @(negedge clk);
        bwr = wr; baddr = a; bwd = d; tick = tk;
        @(posedge clk);
        model_step(wr, a, d, tk);
        #2;
        bwr = 0; tick = 0; baddr = 5'h08;
        #1 check("R3 count low", rdata, m_cnt[31:0]);
        baddr = 5'h0C;
        #1 check("R9 count high", rdata, m_cnt[63:32]);
        check("R8 irq", irq, m_pend && m_unmask);
    endtask

    task automatic rd(logic [4:0] a, output logic [31:0] v);
        @(negedge clk);
        bwr = 0; tick = 0; baddr = a;
        #1 v = rdata;
    endtask

    task automatic wr(logic [4:0] a, logic [31:0] d);
        cyc(1, a, d, 0);
    endtask

    task automatic ticks(int n);
        for (int i = 0; i < n; i++) cyc(0, 5'h08, 0, 1);
    endtask

    initial begin
        #2_000_000;
        if (!finished) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 0;

        // R1 reset state
        foreach (v[i]) begin end
        for (int a = 0; a < 32; a += 4) begin
            rd(5'(a), v);
            check("R1 reset read", v, 0);
        end
        check("R1 reset irq", irq, 0);

        // R2 register map and readback
        wr(5'h00, 32'hA5A5_0001);
        wr(5'h04, 32'h0000_00C3);
        rd(5'h00, v); check("R2 load low readback", v, 32'hA5A5_0001);
        rd(5'h04, v); check("R2 load high readback", v, 32'h0000_00C3);
        wr(5'h10, 32'hFFFF_FFF6);            // en=0, mode=1, unmask=1
        rd(5'h10, v); check("R2 ctrl readback", v, 32'h6);
        rd(5'h14, v); check("R2 unmapped read", v, 0);
        rd(5'h1C, v); check("R2 unmapped read", v, 0);

        // R3 ticks ignored while disabled
        ticks(5);
        rd(5'h08, v); check("R3 disabled count", v, 0);

        // R4 periodic: load 3 -> expiry every 4 ticks
        wr(5'h10, 0);
        wr(5'h00, 3); wr(5'h04, 0);
        wr(5'h10, 32'h5);                    // en, periodic, unmasked
        rd(5'h08, v); check("R3 start loads", v, 3);
        ticks(3);
        rd(5'h18, v); check("R4 no early expiry", v, 0);
        ticks(1);
        rd(5'h18, v); check("R4 expiry on 4th tick", v, 1);
        check("R8 irq raised", irq, 1);
        rd(5'h08, v); check("R4 reload", v, 3);
        ticks(2);
        check("R8 irq level held", irq, 1);
        wr(5'h18, 32'h0);
        check("R7 write zero keeps pending", irq, 1);
        wr(5'h18, 32'h1);
        rd(5'h18, v); check("R7 cleared", v, 0);
        check("R8 irq dropped", irq, 0);

        // R6 load writes while running do not disturb
        wr(5'h00, 10);
        rd(5'h08, v); check("R6 count unchanged", v, 1);
        ticks(2);
        rd(5'h18, v); check("R6 expiry on old schedule", v, 1);
        rd(5'h08, v); check("R6 reload uses captured value", v, 3);
        wr(5'h18, 1);

        // R10 re-write of ctrl while enabled does not restart
        ticks(1);
        wr(5'h10, 32'h1);                    // mask off, still enabled
        rd(5'h08, v); check("R10 no restart", v, 2);
        wr(5'h10, 32'h5);

        // R5 single-shot
        wr(5'h10, 0);
        wr(5'h00, 2);
        wr(5'h18, 1);
        wr(5'h10, 32'h7);
        ticks(2);
        rd(5'h18, v); check("R5 not yet", v, 0);
        ticks(1);
        rd(5'h18, v); check("R5 single expiry", v, 1);
        wr(5'h18, 1);
        ticks(6);
        rd(5'h18, v); check("R5 no second expiry", v, 0);
        rd(5'h08, v); check("R5 parked at zero", v, 0);

        // R8 mask gating
        wr(5'h10, 0);
        wr(5'h10, 32'h3);                    // en, single-shot, masked
        ticks(3);
        rd(5'h18, v); check("R7 pending while masked", v, 1);
        check("R8 masked irq low", irq, 0);
        wr(5'h10, 32'h7);
        check("R8 unmask raises irq", irq, 1);

        // R9 borrow across the halves
        wr(5'h10, 0);
        wr(5'h00, 0); wr(5'h04, 1);
        wr(5'h18, 1);
        wr(5'h10, 32'h1);
        ticks(1);
        rd(5'h08, v); check("R9 low after borrow", v, 32'hFFFF_FFFF);
        rd(5'h0C, v); check("R9 high after borrow", v, 0);

        // R7 expiry wins over a same-cycle clear
        wr(5'h10, 0);
        wr(5'h04, 0);
        wr(5'h10, 32'h5);                    // load 0: every tick expires
        cyc(1, 5'h18, 1, 1);
        rd(5'h18, v); check("R7 set beats clear", v, 1);
        wr(5'h18, 1);
        rd(5'h18, v); check("R7 clear", v, 0);

        // irregular tick pattern, periodic, load 5, compared every clock
        wr(5'h10, 0);
        wr(5'h00, 5);
        wr(5'h10, 32'h5);
        for (int i = 0; i < 200; i++) begin
            if (i % 37 == 20) cyc(1, 5'h18, 1, (i % 3) != 0);
            else              cyc(0, 5'h08, 0, (i % 3) != 0 && (i % 7) != 4);
        end

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule